// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a word-wide command channel and the nonvolatile memory controllers of a chip. Words arrive one per valid/ready handshake. A separate strobe marks each word as either a command word or a data word. The sequencer decodes each command word and then does one of the following:

- returns the general-purpose fuse bits as a mask,
- switches which of two flash controllers receives later operations,
- streams a burst of memory writes at an address that advances by four bytes per word,
- hands a controller operation on unchanged.

A set-security command places the block in a sticky locked state. In that state every later command is refused. The state ends only when a rising edge on the external erase pin has started an erase-all request and that request has been acknowledged.

The block talks to the memory side through a single request port. The port carries valid, a kind code, the target controller, an address and a data word, and it is held until acknowledged. While a request waits, the command channel is back-pressured. The flash array, the pulse timing and the analog erase circuit sit outside this block.

Top module: `nvm_cmd_seq`

## Requirements
- R1: After reset, in_ready is 1, req_valid, rd_valid, cmd_err and secure are 0, and controller 0 is current.
- R2: A command word with bits 15:0 = 0x0004 starts a burst write, and its bits 31:16 give the word count N. The next data word is the start address A. Each data word i (i = 0..N-1) after it raises one request with req_kind = 1, req_addr = A + 4*i and req_data = that word. After N words the sequencer is idle again.
- R3: A burst write with N = 0 returns to idle right after the address word, with no request. A following data word is ignored.
- R4: A word is taken only when in_valid and in_ready are both 1. From the cycle after a word raises a request until the cycle after req_ack is seen, in_ready is 0. During that time req_kind, req_sel, req_addr and req_data hold steady.
- R5: Opcode 0x000D (bits 15:0) is the fuse read. One cycle after acceptance, rd_valid is 1 for one cycle and rd_data equals fuse_bits zero-extended.
- R6: Opcode 0x0008 is the controller select. Bit 0 of the next data word picks the controller (0 or 1). Later controller operations carry that value on req_sel.
- R7: Opcodes 0x0001 (page write), 0x0002 (erase all), 0x0003 (lock) and 0x000B (fuse set) each raise one request with req_kind = 0, req_data equal to the whole command word, and req_sel equal to the current controller.
- R8: Any other opcode gives a one-cycle cmd_err pulse the cycle after acceptance, raises no request and leaves the sequencer idle.
- R9: Opcode 0x000F is set-security. With controller 0 current, secure is 1 from the next cycle onward. With controller 1 current, the command is refused with cmd_err and secure stays 0.
- R10: While secure is 1, every command word is refused with a cmd_err pulse, with no request and no rd_valid.
- R11: While secure is 1, a rising edge on erase_pin is seen after a two-flop synchroniser. The request then appears three clock edges after the pin rises, with req_kind = 2 and req_sel = 0. secure drops at the edge that samples its req_ack. An erase_pin edge while secure is 0 has no effect.
- R12: A command word accepted in the middle of a select or burst sequence abandons that sequence and is decoded on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Sequencer can take a word |
| in_data | input | DATA_W | Command or data word |
| in_is_cmd | input | 1 | 1: word is a command, 0: data |
| fuse_bits | input | FUSE_W | Current fuse bit values |
| erase_pin | input | 1 | External erase pin (asynchronous) |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | DATA_W | Fuse mask read result |
| cmd_err | output | 1 | Command refused or unknown (pulse) |
| secure | output | 1 | Security lock active |
| req_valid | output | 1 | Memory-side request pending |
| req_kind | output | 2 | 0 controller op, 1 memory write, 2 erase all |
| req_sel | output | 1 | Target controller |
| req_addr | output | ADDR_W | Write address |
| req_data | output | DATA_W | Write data or forwarded command word |
| req_ack | input | 1 | Memory side took the request |

## Verification
The bound checker watches the request port and the lock on every cycle. It checks that in_ready stays low while a request is pending and that a pending request does not change. It also checks that a locked sequencer emits nothing except an erase to controller 0, that secure falls only right after an erase is acknowledged, and that an error pulse never comes with a new request. The directed scenarios are the only place the decoded content is shown: burst addresses stepping by four, the zero-count burst, fuse mask values, controller steering, refusal of set-security on controller 1, aborting a sequence, and the exact latency of the erase pin.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    localparam int CNT_W   = 16;
    localparam int CNT_LSB = 16;
    localparam int OPC_W   = 16;

    localparam logic [OPC_W-1:0] OPC_FUSE_RD   = 16'h000D;
    localparam logic [OPC_W-1:0] OPC_SEC_SET   = 16'h000F;
    localparam logic [OPC_W-1:0] OPC_CTRL_SEL  = 16'h0008;
    localparam logic [OPC_W-1:0] OPC_BURST     = 16'h0004;
    localparam logic [OPC_W-1:0] OPC_PAGE_WR   = 16'h0001;
    localparam logic [OPC_W-1:0] OPC_ERASE_ALL = 16'h0002;
    localparam logic [OPC_W-1:0] OPC_LOCK      = 16'h0003;
    localparam logic [OPC_W-1:0] OPC_FUSE_SET  = 16'h000B;

    typedef enum logic [2:0] {
        CLS_BAD, CLS_FUSE_RD, CLS_SEC_SET, CLS_CTRL_SEL, CLS_BURST, CLS_PASS
    } cmd_cls_e;

    typedef enum logic [1:0] {
        RK_PASS  = 2'd0,
        RK_MEMWR = 2'd1,
        RK_ERASE = 2'd2
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEL, ST_ADDR, ST_DATA, ST_ERASE
    } seq_state_e;

    typedef struct packed {
        req_kind_e kind;
        logic      sel;
    } req_hdr_t;

    function automatic cmd_cls_e classify(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_FUSE_RD:  return CLS_FUSE_RD;
            OPC_SEC_SET:  return CLS_SEC_SET;
            OPC_CTRL_SEL: return CLS_CTRL_SEL;
            OPC_BURST:    return CLS_BURST;
            OPC_PAGE_WR, OPC_ERASE_ALL, OPC_LOCK, OPC_FUSE_SET: return CLS_PASS;
            default:      return CLS_BAD;
        endcase
    endfunction

endpackage

// File: rtl/nvm_cmd_decode.sv
module nvm_cmd_decode
    import nvm_cmd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word,
    output cmd_cls_e          cls,
    output logic [CNT_W-1:0]  count
);
    logic [OPC_W-1:0] opc;

    assign opc   = word[OPC_W-1:0];
    assign cls   = classify(opc);
    assign count = word[CNT_LSB +: CNT_W];
endmodule

// File: rtl/nvm_burst_track.sv
module nvm_burst_track #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_cnt,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  remain
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            remain <= '0;
        end else begin
            if (load_cnt)
                remain <= cnt_in;
            else if (step)
                remain <= remain - CNT_W'(1);
            if (load_addr)
                addr <= addr_in;
            else if (step)
                addr <= addr + STEP_V;
        end
    end
endmodule

// File: rtl/nvm_sec_lock.sv
module nvm_sec_lock #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic erase_pin,
    input  logic set_lock,
    input  logic clear_lock,
    output logic locked,
    output logic erase_rise
);
    logic pin_s;
    logic pin_prev;

    generate
        if (SYNC_N == 0) begin : g_nosync
            assign pin_s = erase_pin;
        end else if (SYNC_N == 1) begin : g_sync1
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b0;
                else     s_q <= erase_pin;
            end
            assign pin_s = s_q;
        end else begin : g_syncn
            logic [SYNC_N-1:0] s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= '0;
                else     s_q <= {s_q[SYNC_N-2:0], erase_pin};
            end
            assign pin_s = s_q[SYNC_N-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev <= 1'b0;
            locked   <= 1'b0;
        end else begin
            pin_prev <= pin_s;
            if (clear_lock)
                locked <= 1'b0;
            else if (set_lock)
                locked <= 1'b1;
        end
    end

    assign erase_rise = pin_s & ~pin_prev;
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
    import nvm_cmd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int FUSE_W     = 8,
    parameter int ADDR_STEP  = 4,
    parameter int ERASE_SYNC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_is_cmd,
    input  logic [FUSE_W-1:0] fuse_bits,
    input  logic              erase_pin,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_err,
    output logic              secure,
    output logic              req_valid,
    output logic [1:0]        req_kind,
    output logic              req_sel,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    input  logic              req_ack
);
    localparam int SEL_BIT = 0;

    seq_state_e        state_q;
    logic              ctrl_q;
    logic              req_valid_q;
    req_hdr_t          hdr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    cmd_cls_e          dec_cls;
    logic [CNT_W-1:0]  dec_cnt;
    logic [ADDR_W-1:0] b_addr;
    logic [CNT_W-1:0]  b_rem;
    logic              e_rise;

    logic accept, cmd_acc, data_acc;
    logic ld_cnt, ld_addr, bstep;
    logic sec_set, sec_clr, ack_hit, erase_go;

    nvm_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .word  (in_data),
        .cls   (dec_cls),
        .count (dec_cnt)
    );

    nvm_burst_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(ADDR_STEP)) u_burst (
        .clk       (clk),
        .rst       (rst),
        .load_cnt  (ld_cnt),
        .cnt_in    (dec_cnt),
        .load_addr (ld_addr),
        .addr_in   (ADDR_W'(in_data)),
        .step      (bstep),
        .addr      (b_addr),
        .remain    (b_rem)
    );

    nvm_sec_lock #(.SYNC_N(ERASE_SYNC)) u_sec (
        .clk        (clk),
        .rst        (rst),
        .erase_pin  (erase_pin),
        .set_lock   (sec_set),
        .clear_lock (sec_clr),
        .locked     (secure),
        .erase_rise (e_rise)
    );

    always_comb begin
        erase_go = secure & e_rise & ~req_valid_q & (state_q == ST_IDLE);
        in_ready = ~req_valid_q & (state_q != ST_ERASE) & ~erase_go;
        accept   = in_valid & in_ready;
        cmd_acc  = accept & in_is_cmd & ~secure;
        data_acc = accept & ~in_is_cmd & ~secure;
        ld_cnt   = cmd_acc & (dec_cls == CLS_BURST);
        ld_addr  = data_acc & (state_q == ST_ADDR);
        bstep    = data_acc & (state_q == ST_DATA);
        sec_set  = cmd_acc & (dec_cls == CLS_SEC_SET) & ~ctrl_q;
        ack_hit  = req_valid_q & req_ack;
        sec_clr  = ack_hit & (state_q == ST_ERASE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            ctrl_q      <= 1'b0;
            req_valid_q <= 1'b0;
            hdr_q       <= '{kind: RK_PASS, sel: 1'b0};
            addr_q      <= '0;
            data_q      <= '0;
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            cmd_err     <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            cmd_err  <= 1'b0;
            if (ack_hit) begin
                req_valid_q <= 1'b0;
                if (state_q == ST_ERASE)
                    state_q <= ST_IDLE;
            end else if (erase_go) begin
                req_valid_q <= 1'b1;
                hdr_q       <= '{kind: RK_ERASE, sel: 1'b0};
                addr_q      <= '0;
                data_q      <= '0;
                state_q     <= ST_ERASE;
            end else if (accept && secure) begin
                if (in_is_cmd)
                    cmd_err <= 1'b1;
            end else if (cmd_acc) begin
                state_q <= ST_IDLE;
                case (dec_cls)
                    CLS_FUSE_RD: begin
                        rd_data  <= DATA_W'(fuse_bits);
                        rd_valid <= 1'b1;
                    end
                    CLS_SEC_SET: begin
                        if (ctrl_q)
                            cmd_err <= 1'b1;
                    end
                    CLS_CTRL_SEL: state_q <= ST_SEL;
                    CLS_BURST:    state_q <= ST_ADDR;
                    CLS_PASS: begin
                        req_valid_q <= 1'b1;
                        hdr_q       <= '{kind: RK_PASS, sel: ctrl_q};
                        addr_q      <= '0;
                        data_q      <= in_data;
                    end
                    default: cmd_err <= 1'b1;
                endcase
            end else if (data_acc) begin
                case (state_q)
                    ST_SEL: begin
                        ctrl_q  <= in_data[SEL_BIT];
                        state_q <= ST_IDLE;
                    end
                    ST_ADDR: begin
                        state_q <= (b_rem == '0) ? ST_IDLE : ST_DATA;
                    end
                    ST_DATA: begin
                        req_valid_q <= 1'b1;
                        hdr_q       <= '{kind: RK_MEMWR, sel: ctrl_q};
                        addr_q      <= b_addr;
                        data_q      <= in_data;
                        if (b_rem == CNT_W'(1))
                            state_q <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign req_valid = req_valid_q;
    assign req_kind  = hdr_q.kind;
    assign req_sel   = hdr_q.sel;
    assign req_addr  = addr_q;
    assign req_data  = data_q;
endmodule

// File: rtl/nvm_cmd_seq_chk.sv
module nvm_cmd_seq_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int FUSE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              in_is_cmd,
    input logic [FUSE_W-1:0] fuse_bits,
    input logic              erase_pin,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              cmd_err,
    input logic              secure,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              req_sel,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_data,
    input logic              req_ack
);
    AST_NO_READY_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !in_ready); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_kind) && $stable(req_sel)
                                     && $stable(req_addr) && $stable(req_data))); // R4

    AST_LOCKED_NO_READ: assert property (@(posedge clk) disable iff (rst)
        secure |-> !rd_valid); // R10

    AST_LOCKED_ONLY_ERASE: assert property (@(posedge clk) disable iff (rst)
        (secure && req_valid) |-> (req_kind == 2'd2)); // R10

    AST_ERASE_TO_CTRL0: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2) |-> (req_sel == 1'b0)); // R11

    AST_UNLOCK_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(secure) |-> $past(req_valid && req_ack && req_kind == 2'd2)); // R11

    AST_ERR_NO_NEW_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> !cmd_err); // R8
endmodule

bind nvm_cmd_seq nvm_cmd_seq_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FUSE_W(FUSE_W)
) u_chk (.*);

// File: tb/nvm_cmd_seq_test.sv
`timescale 1ns/1ps
module nvm_cmd_seq_test;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int FUSE_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_is_cmd = 1'b0;
    logic [FUSE_W-1:0] fuse_bits = '0;
    logic              erase_pin = 1'b0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              cmd_err;
    logic              secure;
    logic              req_valid;
    logic [1:0]        req_kind;
    logic              req_sel;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;
    logic              req_ack = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    nvm_cmd_seq uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_is_cmd(in_is_cmd), .fuse_bits(fuse_bits),
        .erase_pin(erase_pin), .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_err(cmd_err), .secure(secure), .req_valid(req_valid),
        .req_kind(req_kind), .req_sel(req_sel), .req_addr(req_addr),
        .req_data(req_data), .req_ack(req_ack)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic is_cmd, input logic [31:0] w);
        @(negedge clk);
        in_valid  = 1'b1;
        in_is_cmd = is_cmd;
        in_data   = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic ack_req(input string tag, input logic [1:0] kind, input logic sel,
                           input logic [31:0] addr, input logic [31:0] data);
        chk(tag, "req_valid", 32'(req_valid), 32'd1);
        chk(tag, "req_kind", 32'(req_kind), 32'(kind));
        chk(tag, "req_sel", 32'(req_sel), 32'(sel));
        chk(tag, "req_addr", req_addr, addr);
        chk(tag, "req_data", req_data, data);
        chk(tag, "in_ready low while pending", 32'(in_ready), 32'd0);
        @(negedge clk);
        chk(tag, "req held", {req_valid, req_addr[30:0]}, {1'b1, addr[30:0]});
        req_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ack = 1'b0;
        chk(tag, "req dropped after ack", 32'(req_valid), 32'd0);
        chk(tag, "ready back after ack", 32'(in_ready), 32'd1);
    endtask

    task automatic t_reset;
        chk("R1", "in_ready", 32'(in_ready), 32'd1);
        chk("R1", "req_valid", 32'(req_valid), 32'd0);
        chk("R1", "rd_valid", 32'(rd_valid), 32'd0);
        chk("R1", "cmd_err", 32'(cmd_err), 32'd0);
        chk("R1", "secure", 32'(secure), 32'd0);
        send(1'b1, 32'h0000_0001);
        ack_req("R1", 2'd0, 1'b0, 32'h0, 32'h0000_0001);
    endtask

    task automatic t_fuse;
        fuse_bits = 8'hA5;
        send(1'b1, 32'h0000_000D);
        chk("R5", "rd_valid", 32'(rd_valid), 32'd1);
        chk("R5", "rd_data A5", rd_data, 32'h0000_00A5);
        @(negedge clk);
        chk("R5", "rd_valid one cycle", 32'(rd_valid), 32'd0);
        fuse_bits = 8'h3C;
        send(1'b1, 32'h0000_000D);
        chk("R5", "rd_data 3C", rd_data, 32'h0000_003C);
    endtask

    task automatic t_pass_and_select;
        send(1'b1, 32'h1234_0002);
        ack_req("R7", 2'd0, 1'b0, 32'h0, 32'h1234_0002);
        send(1'b1, 32'h0000_0008);
        send(1'b0, 32'h0000_0001);
        send(1'b1, 32'h00AB_0003);
        ack_req("R6", 2'd0, 1'b1, 32'h0, 32'h00AB_0003);
        send(1'b1, 32'h0000_000B);
        ack_req("R7", 2'd0, 1'b1, 32'h0, 32'h0000_000B);
        send(1'b1, 32'h0000_0008);
        send(1'b0, 32'hFFFF_FFFE);
        send(1'b1, 32'h0000_0001);
        ack_req("R6", 2'd0, 1'b0, 32'h0, 32'h0000_0001);
    endtask

    task automatic t_burst;
        send(1'b1, 32'h0003_0004);
        send(1'b0, 32'h0000_0100);
        chk("R2", "no req after address", 32'(req_valid), 32'd0);
        for (int i = 0; i < 3; i++) begin
            send(1'b0, 32'hD000_0000 + 32'(i));
            ack_req("R2", 2'd1, 1'b0, 32'h100 + 32'(4 * i), 32'hD000_0000 + 32'(i));
        end
        send(1'b0, 32'hBEEF_0000);
        chk("R2", "idle after count", 32'(req_valid), 32'd0);
    endtask

    task automatic t_burst_zero;
        send(1'b1, 32'h0000_0004);
        send(1'b0, 32'h0000_0200);
        chk("R3", "no req after address", 32'(req_valid), 32'd0);
        send(1'b0, 32'h5555_5555);
        chk("R3", "data ignored", 32'(req_valid), 32'd0);
        chk("R3", "ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_abort;
        fuse_bits = 8'h81;
        send(1'b1, 32'h0002_0004);
        send(1'b0, 32'h0000_0400);
        send(1'b1, 32'h0000_000D);
        chk("R12", "rd_valid after abort", 32'(rd_valid), 32'd1);
        chk("R12", "rd_data", rd_data, 32'h0000_0081);
        send(1'b0, 32'h7777_7777);
        chk("R12", "burst abandoned", 32'(req_valid), 32'd0);
    endtask

    task automatic t_bad;
        send(1'b1, 32'h0000_0055);
        chk("R8", "cmd_err", 32'(cmd_err), 32'd1);
        chk("R8", "no req", 32'(req_valid), 32'd0);
        @(negedge clk);
        chk("R8", "err one cycle", 32'(cmd_err), 32'd0);
    endtask

    task automatic t_sec_refused;
        send(1'b1, 32'h0000_0008);
        send(1'b0, 32'h0000_0001);
        send(1'b1, 32'h0000_000F);
        chk("R9", "refused on ctrl1 err", 32'(cmd_err), 32'd1);
        @(negedge clk);
        chk("R9", "secure stays 0", 32'(secure), 32'd0);
        send(1'b1, 32'h0000_0008);
        send(1'b0, 32'h0000_0000);
    endtask

    task automatic t_erase_unlocked;
        erase_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11", "pin ignored when unlocked", 32'(req_valid), 32'd0);
        erase_pin = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_secure;
        send(1'b1, 32'h0000_000F);
        chk("R9", "secure set", 32'(secure), 32'd1);
        chk("R9", "no err", 32'(cmd_err), 32'd0);
        send(1'b1, 32'h0000_000D);
        chk("R10", "fuse read refused err", 32'(cmd_err), 32'd1);
        chk("R10", "no rd_valid", 32'(rd_valid), 32'd0);
        send(1'b1, 32'h0000_0002);
        chk("R10", "pass refused err", 32'(cmd_err), 32'd1);
        chk("R10", "no req", 32'(req_valid), 32'd0);
    endtask

    task automatic t_erase;
        @(negedge clk);
        erase_pin = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11", "no req before sync", 32'(req_valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R11", "still secure before ack", 32'(secure), 32'd1);
        ack_req("R11", 2'd2, 1'b0, 32'h0, 32'h0);
        chk("R11", "secure cleared", 32'(secure), 32'd0);
        erase_pin = 1'b0;
        fuse_bits = 8'h42;
        send(1'b1, 32'h0000_000D);
        chk("R11", "commands accepted again", rd_data, 32'h0000_0042);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fuse();
        t_pass_and_select();
        t_burst();
        t_burst_zero();
        t_abort();
        t_bad();
        t_sec_refused();
        t_erase_unlocked();
        t_secure();
        t_erase();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule